// File: doc/BRIEF.md
# Watchdog Configuration Register with Two-Wire Serial Access

This block is a two-wire serial slave that owns a single 8-bit configuration register. The register carries a two-bit watchdog period selection, which survives power loss in the real system and is modelled here as a register with a self-timed busy interval after each store, and two volatile enable latches. Before the period bits can change, software must unlock them in stages: first arm the write latch, then arm the register latch, then write the new period. Any step taken out of order is refused with a missing acknowledge.

The block sees already-synchronised copies of the clock and data lines. It drives a single pull-down enable for the data line, so the open-drain wiring stays outside the block. A write-protect input locks the register. An abort input, raised by the system reset logic, cancels any transfer in progress. The current period bits are presented continuously to the watchdog timer.

A read is done as a dummy write of the device and register address, followed by a repeated start with the read flag set. Exactly one register image is returned.

Top module: `wdcfg_i2c_ctl`

## Requirements
- R1: The device byte must be 1011000 in its upper seven bits; bit 0 selects read (1) or write (0). Any other device byte gets no acknowledge and the slave ignores the bus until the next start or stop.
- R2: In a write, the byte after the device byte must be FFh to be acknowledged. Any other value is refused, and the frame is then ignored.
- R3: After reset the period bits are 11 (watchdog off) and both latches are clear. The register image, from bit 7 down to bit 0, is 0, P1, P0, 0, 0, RL, WL, 0, where P1:P0 are the period bits, RL is the register latch and WL is the write latch.
- R4: A data byte of 02h with the register latch clear sets the write latch. A data byte of 00h clears the write latch. Both are acknowledged even while the write latch is clear. Any other byte is refused while the write latch is clear, and nothing changes.
- R5: A byte whose bit 7 is 0 and whose bits 4:0 are 00110, written with the write latch set and the register latch clear, sets the register latch and leaves the period bits unchanged.
- R6: With the register latch set, a byte 0xy00010 stores xy into the period bits, clears the register latch and starts a busy interval of BUSY_CYCLES clocks. A byte 0xy00110 is acknowledged and changes nothing.
- R7: During the busy interval the slave never pulls the data line low, so every byte goes unacknowledged.
- R8: While write protect is high, a data byte is refused, the period bits and the write latch keep their values, and the register latch is cleared.
- R9: A second data byte in one write frame is refused, and the pending update is dropped, even when a stop follows.
- R10: A stop that arrives before a data byte and its acknowledge have completed leaves the register unchanged.
- R11: A read returns one image MSB first. The data line changes only while the clock is low, and the slave goes idle after the byte. A read request with no preceding register address in the same transaction is refused.
- R12: A read placed between unlock steps leaves both latches as they were.
- R13: Raising abort returns the slave to idle, releases the data line and drops any pending update.
- R14: An acknowledge is a pull-down held from the clock fall after bit 8 until the clock fall that ends the ninth clock.
- Updates take effect on the stop that ends an accepted one-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up state) |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (wired line level) |
| wp_i | input | 1 | Write protect, high locks the register |
| abort_i | input | 1 | Cancels the transfer in progress |
| sda_pull_o | output | 1 | When high, pull the data line low |
| wd_period_o | output | 2 | Current watchdog period selection |

## Verification
The bench builds the block with BUSY_CYCLES set to 400. This is long enough that a whole device byte sent right after a store falls inside the busy window. It is short enough that the window expires, and the stored value can be read back, within a short run. At the default of 500000, which is about 10 ms at 50 MHz, the window would dominate the run. The bus runs four system clocks per quarter bit, so the edge detector sees every level for several cycles. The bench drives the full unlock sequence, its out-of-order variants, protected writes, aborts and truncated frames.

// File: rtl/wdcfg_pkg.sv
package wdcfg_pkg;

  localparam logic [6:0] DEV_ID   = 7'b1011000;
  localparam logic [7:0] REG_ADDR = 8'hFF;

  typedef enum logic [2:0] {
    OP_NONE, OP_SET_WEL, OP_CLR_WEL, OP_SET_RWEL, OP_KEEP, OP_STORE
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_ADDR, PH_DATA, PH_EXTRA, PH_SEND, PH_SKIP
  } phase_e;

  typedef struct packed {
    logic       ack;
    op_e        op;
    logic [1:0] wd;
  } verdict_t;

  // Decide acknowledge and effect for one data byte.
  function automatic verdict_t judge(input logic [7:0] d, input logic wel,
                                     input logic rwel, input logic wp);
    verdict_t v;
    v.ack = 1'b0;
    v.op  = OP_NONE;
    v.wd  = d[6:5];
    if (!wp) begin
      if ((d & 8'h9F) == 8'h02) begin
        if (rwel) begin
          v.ack = 1'b1; v.op = OP_STORE;
        end else if (d[6:5] == 2'b00) begin
          v.ack = 1'b1; v.op = OP_SET_WEL;
        end
      end else if ((d & 8'h9F) == 8'h06) begin
        if (rwel) begin
          v.ack = 1'b1; v.op = OP_KEEP;
        end else if (wel) begin
          v.ack = 1'b1; v.op = OP_SET_RWEL;
        end
      end else if (d == 8'h00) begin
        v.ack = 1'b1; v.op = OP_CLR_WEL;
      end
    end
    return v;
  endfunction

  // Register image as returned by a read.
  function automatic logic [7:0] reg_image(input logic [1:0] wd, input logic rwel,
                                           input logic wel);
    return {1'b0, wd, 2'b00, rwel, wel, 1'b0};
  endfunction

endpackage

// File: rtl/wdcfg_line_events.sv
module wdcfg_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/wdcfg_store.sv
module wdcfg_store
  import wdcfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit_i,
  input  op_e        op_i,
  input  logic [1:0] wd_i,
  input  logic       prot_hit_i,
  output logic [1:0] wd_o,
  output logic       wel_o,
  output logic       rwel_o,
  output logic       busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] busy_cnt;
  logic          store_evt;

  assign store_evt = commit_i && (op_i == OP_STORE);
  assign busy_o    = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_o     <= 2'b11;
      wel_o    <= 1'b0;
      rwel_o   <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - CW'(1);
      if (prot_hit_i) rwel_o <= 1'b0;
      if (commit_i) begin
        case (op_i)
          OP_SET_WEL:  wel_o  <= 1'b1;
          OP_CLR_WEL:  wel_o  <= 1'b0;
          OP_SET_RWEL: rwel_o <= 1'b1;
          OP_STORE: begin
            wd_o     <= wd_i;
            rwel_o   <= 1'b0;
            busy_cnt <= CW'(BUSY_CYCLES);
          end
          default: ;
        endcase
      end
    end
  end

  // R6: a store only happens with the register latch armed
  assert_store_needs_rwel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |-> rwel_o);
  // R6: period bits move only on a store
  assert_wd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !store_evt |=> $stable(wd_o));
  // R7: a store opens the busy window
  assert_busy_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> busy_o);
endmodule

// File: rtl/wdcfg_bus_fsm.sv
module wdcfg_bus_fsm
  import wdcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       sda_i,
  input  logic       abort_i,
  input  logic       busy_i,
  input  logic       wp_i,
  input  logic       wel_i,
  input  logic       rwel_i,
  input  logic [1:0] wd_i,
  output logic       sda_pull_o,
  output logic       commit_o,
  output op_e        op_o,
  output logic [1:0] cwd_o,
  output logic       prot_hit_o
);
  phase_e     ph;
  logic [3:0] bitn;
  logic [7:0] rx;
  logic [7:0] tx;
  logic       addr_ok;
  logic       held_ok;
  verdict_t   held;
  verdict_t   v_now;
  logic       ack_now;
  logic       byte_done;
  logic       ack_done;
  logic       receiving;
  logic [7:0] img;

  assign v_now     = judge(rx, wel_i, rwel_i, wp_i);
  assign img       = reg_image(wd_i, rwel_i, wel_i);
  assign byte_done = scl_fall && (bitn == 4'd8);
  assign ack_done  = scl_fall && (bitn == 4'd9);
  assign receiving = ph inside {PH_DEV, PH_ADDR, PH_DATA, PH_EXTRA};

  always_comb begin
    ack_now = 1'b0;
    case (ph)
      PH_DEV:  ack_now = (rx[7:1] == DEV_ID) && (!rx[0] || addr_ok);
      PH_ADDR: ack_now = (rx == REG_ADDR);
      PH_DATA: ack_now = v_now.ack;
      default: ack_now = 1'b0;
    endcase
  end

  assign prot_hit_o = byte_done && (ph == PH_DATA) && wp_i;
  assign commit_o   = stop_evt && (ph == PH_EXTRA) && held_ok && !busy_i && !abort_i;
  assign op_o       = held.op;
  assign cwd_o      = held.wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      bitn       <= '0;
      rx         <= '0;
      tx         <= '0;
      addr_ok    <= 1'b0;
      held_ok    <= 1'b0;
      held       <= '0;
      sda_pull_o <= 1'b0;
    end else if (busy_i || abort_i) begin
      ph         <= PH_IDLE;
      bitn       <= '0;
      addr_ok    <= 1'b0;
      held_ok    <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start_evt) begin
      ph         <= PH_DEV;
      bitn       <= '0;
      held_ok    <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_evt) begin
      ph         <= PH_IDLE;
      addr_ok    <= 1'b0;
      held_ok    <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (ph == PH_SEND) begin
      if (scl_rise) bitn <= bitn + 4'd1;
      if (scl_fall) begin
        if (bitn == 4'd8) begin
          sda_pull_o <= 1'b0;
          ph         <= PH_IDLE;
          addr_ok    <= 1'b0;
        end else begin
          tx         <= {tx[6:0], 1'b0};
          sda_pull_o <= ~tx[6];
        end
      end
    end else if (receiving) begin
      if (scl_rise && bitn < 4'd8) begin
        rx   <= {rx[6:0], sda_i};
        bitn <= bitn + 4'd1;
      end
      if (byte_done) begin
        sda_pull_o <= ack_now;
        bitn       <= 4'd9;
        if (ph == PH_DATA)  held    <= v_now;
        if (ph == PH_EXTRA) held_ok <= 1'b0;
      end
      if (ack_done) begin
        bitn       <= '0;
        sda_pull_o <= 1'b0;
        if (!sda_pull_o) begin
          ph <= PH_SKIP;
        end else begin
          case (ph)
            PH_DEV: begin
              if (rx[0]) begin
                ph         <= PH_SEND;
                tx         <= img;
                sda_pull_o <= ~img[7];
              end else begin
                ph <= PH_ADDR;
              end
            end
            PH_ADDR: begin
              ph      <= PH_DATA;
              addr_ok <= 1'b1;
            end
            PH_DATA: begin
              ph      <= PH_EXTRA;
              held_ok <= 1'b1;
            end
            default: ph <= PH_SKIP;
          endcase
        end
      end
    end
  end

  // R7: silent on the bus while the store is busy
  assert_quiet_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !sda_pull_o);
  // R11: pull-down changes only while the clock is low
  assert_pull_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_o) && !$past(abort_i)) |-> !scl_q);
  // R9: a second data byte is never acknowledged
  assert_no_extra_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_EXTRA) |-> !sda_pull_o);
  // R14: outside a read, the pull-down is only the ninth-clock acknowledge
  assert_ack_slot_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o && ph != PH_SEND) |-> (bitn == 4'd9));
  // R10: only an acknowledged byte can commit
  assert_commit_acked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> held.ack);
endmodule

// File: rtl/wdcfg_i2c_ctl.sv
module wdcfg_i2c_ctl
  import wdcfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic       abort_i,
  output logic       sda_pull_o,
  output logic [1:0] wd_period_o
);
  logic       scl_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic       commit, prot_hit, busy, wel, rwel;
  op_e        op;
  logic [1:0] cwd;

  wdcfg_line_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  wdcfg_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_i(sda_i), .abort_i(abort_i), .busy_i(busy), .wp_i(wp_i),
    .wel_i(wel), .rwel_i(rwel), .wd_i(wd_period_o),
    .sda_pull_o(sda_pull_o), .commit_o(commit), .op_o(op), .cwd_o(cwd),
    .prot_hit_o(prot_hit)
  );

  wdcfg_store #(.BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .op_i(op), .wd_i(cwd),
    .prot_hit_i(prot_hit), .wd_o(wd_period_o), .wel_o(wel), .rwel_o(rwel),
    .busy_o(busy)
  );
endmodule

// File: tb/test_wdcfg_i2c_ctl.sv
module test_wdcfg_i2c_ctl;
  localparam int BUSY = 400;
  localparam int Q    = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0, abort = 1'b0;
  logic pull;
  logic [1:0] wd;
  wire sda_line = sda_m & ~pull;

  always #10 clk = ~clk;

  wdcfg_i2c_ctl #(.BUSY_CYCLES(BUSY)) i_wdcfg_i2c_ctl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
    .abort_i(abort), .sda_pull_o(pull), .wd_period_o(wd)
  );

  int total = 0, bad = 0, cyc = 0;
  bit live = 0, done = 0;
  int m_wd = 3;
  bit m_wel = 0, m_rwel = 0;
  int busy_left = 0;

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (live) begin
      if (busy_left > 0) busy_left--;
      check("R6 R3 period bits per clock", int'(wd), m_wd);
      if (busy_left > 0) check("R7 no pull while busy", int'(pull), 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic b_start();
    sda_m = 1; tk(Q); scl = 1; tk(Q); sda_m = 0; tk(Q); scl = 0; tk(Q);
  endtask

  task automatic b_stop();
    sda_m = 0; tk(Q); scl = 1; tk(Q); sda_m = 1; tk(1);
  endtask

  task automatic b_bit(bit b);
    sda_m = b; tk(Q); scl = 1; tk(2 * Q); scl = 0; tk(Q);
  endtask

  task automatic b_send(int d, output bit ack);
    for (int i = 7; i >= 0; i--) b_bit(d[i]);
    sda_m = 1; tk(Q); scl = 1; tk(Q);
    ack = !sda_line;
    tk(Q); scl = 0; tk(Q);
  endtask

  task automatic b_recv(output int d, output bit steady);
    logic s0;
    d = 0; steady = 1; sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tk(Q); scl = 1; tk(1);
      s0 = sda_line;
      tk(2 * Q - 1);
      if (sda_line !== s0) steady = 0;
      d = (d << 1) | int'(s0);
      scl = 0;
    end
    tk(Q); scl = 1; tk(2 * Q); scl = 0; tk(Q);
  endtask

  // model: expected ack and action for a data byte (1 setwel, 2 clrwel, 3 setrwel, 4 keep, 5 store)
  task automatic model_byte(int d, output bit ok, output int act);
    int xy, low;
    xy = (d >> 5) & 3;
    low = d & 'h9F;
    act = 0;
    if (wp) m_rwel = 0;
    else if (low == 2 && m_rwel) act = 5;
    else if (low == 2 && xy == 0) act = 1;
    else if (low == 6 && m_rwel) act = 4;
    else if (low == 6 && m_wel) act = 3;
    else if (d == 0) act = 2;
    ok = (act != 0);
  endtask

  task automatic model_apply(int act, int d);
    case (act)
      1: m_wel = 1;
      2: m_wel = 0;
      3: m_rwel = 1;
      5: begin m_wd = (d >> 5) & 3; m_rwel = 0; busy_left = BUSY - 2; end
      default: ;
    endcase
  endtask

  task automatic wr(string tag, int d);
    bit a, e;
    int act;
    b_start();
    b_send('hB0, a); check("R1 R14 device write ack", int'(a), 1);
    b_send('hFF, a); check("R2 register address ack", int'(a), 1);
    model_byte(d, e, act);
    b_send(d, a); check(tag, int'(a), int'(e));
    b_stop();
    if (e) model_apply(act, d);
    tk(Q);
  endtask

  task automatic rd(string tag, int exp);
    bit a, st;
    int v;
    b_start();
    b_send('hB0, a); check("R1 read dummy device ack", int'(a), 1);
    b_send('hFF, a); check("R2 read dummy address ack", int'(a), 1);
    b_start();
    b_send('hB1, a); check("R11 device read ack", int'(a), 1);
    b_recv(v, st);
    check("R11 data stable while clock high", int'(st), 1);
    check(tag, v, exp);
    b_stop(); tk(Q);
  endtask

  initial begin
    bit a, e;
    int act;
    tk(5); rst_n = 1; tk(2); live = 1;
    check("R3 reset period", int'(wd), 3);
    check("R3 reset pull", int'(pull), 0);
    rd("R3 reset image", 'h60);

    b_start(); b_send('hA0, a); check("R1 wrong id nack", int'(a), 0); b_stop(); tk(Q);
    b_start(); b_send('hB4, a); check("R1 wrong fixed bits nack", int'(a), 0); b_stop(); tk(Q);
    b_start(); b_send('hB0, a); b_send('h10, a); check("R2 wrong address nack", int'(a), 0);
    b_stop(); tk(Q);

    wr("R4 store byte refused while locked", 'h42);
    rd("R4 image unchanged", 'h60);
    wr("R4 02h sets write latch", 'h02);
    rd("R4 write latch visible", 'h62);
    wr("R4 00h clears write latch", 'h00);
    rd("R4 write latch cleared", 'h60);
    wr("R4 02h again", 'h02);
    wr("R5 06h sets register latch", 'h06);
    rd("R12 R5 read between steps keeps latches", 'h66);
    wr("R6 06h with latch set keeps", 'h06);
    rd("R6 keep leaves register", 'h66);
    wr("R6 store period 01", 'h22);
    check("R6 period output after store", int'(wd), 1);
    tk(BUSY + 20);
    rd("R6 image after store", 'h22);

    wr("R5 rearm register latch", 'h06);
    b_start(); b_send('hB0, a); b_send('hFF, a);
    b_send('h02, a); check("R9 first data byte ack", int'(a), 1);
    b_send('h02, a); check("R9 second data byte nack", int'(a), 0);
    b_stop(); tk(Q);
    rd("R9 no write after second byte", 'h26);

    b_start(); b_send('hB0, a); b_send('hFF, a);
    b_bit(0); b_bit(0); b_bit(1); b_bit(0);
    b_stop(); tk(Q);
    rd("R10 truncated byte leaves register", 'h26);

    wp = 1;
    wr("R8 protected write nack", 'h62);
    wp = 0;
    rd("R8 protected attempt clears register latch only", 'h22);

    wr("R13 rearm", 'h06);
    b_start(); b_send('hB0, a); b_send('hFF, a);
    model_byte('h62, e, act);
    b_send('h62, a); check("R13 byte acked before abort", int'(a), 1);
    abort = 1; tk(1); abort = 0;
    check("R13 line released after abort", int'(pull), 0);
    b_stop(); tk(Q);
    rd("R13 abort drops pending store", 'h26);

    b_start(); b_send('hB1, a); check("R11 read without address nack", int'(a), 0);
    b_stop(); tk(Q);

    wr("R6 store period 11", 'h62);
    b_start(); b_send('hB0, a); check("R7 busy window nack", int'(a), 0);
    b_stop(); tk(BUSY);
    rd("R6 image after final store", 'h62);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule